// File: doc/BRIEF.md
# Buffered Line Error Counter

This block counts one chosen class of transmission errors in a 16-bit saturating counter. Each cycle it takes single-cycle error pulses from the error detectors and adds the ones the source select picks. The sources are bipolar violations and excess-zero events on the line side and on the system side, and pattern-checker errors. Two select codes sum a pair of sources. The detectors themselves sit outside the block.

The running count is double-buffered. An update event copies the count into a holding register that software can read, and in the same cycle the counter restarts from zero. In automatic mode the update event is a once-per-second tick, which also raises a timer status flag. In manual mode the update event is a one-cycle strobe. When an error arrives and the count cannot grow any further, the counter stays at all ones and an overflow status flag is raised. The two status flags drive one interrupt line, and each flag has its own mask.

Top module: `line_err_counter`

## Requirements
- R1: While reset is active and after it is released, the holding value is 0, both status flags are 0 and the interrupt output is 0.
- R2: Select codes pick single sources: 0 = line bipolar violation, 1 = line excess zeros, 3 = system bipolar violation, 4 = system excess zeros, 6 = pattern error. Code 7 counts nothing. Error inputs that the selected source does not use have no effect on the count.
- R3: Select code 2 adds the two line-side inputs and code 5 adds the two system-side inputs. When both inputs of the pair pulse in the same cycle, the count grows by 2.
- R4: While the transmit single-rail NRZ flag is 1, select codes 3 and 5 count nothing.
- R5: When the mode bit is 0 (manual), the update strobe copies the count into the holding value and clears the counter. The one-second tick changes neither the holding value nor the timer status.
- R6: When the mode bit is 1 (automatic), the one-second tick copies the count into the holding value and clears the counter. The update strobe has no effect.
- R7: The holding value changes only on an update event, and the next update event overwrites it.
- R8: An error that arrives in the same cycle as an update event is not part of the transferred value. It counts as the first error of the new interval.
- R9: In automatic mode each tick sets the timer status flag. The flag stays set until the timer clear input is pulsed, and a set in the same cycle as a clear wins.
- R10: The counter saturates at 0xFFFF. When an error would take the count past 0xFFFF, the overflow status flag sets. The flag stays set until the overflow clear input is pulsed, and a set in the same cycle as a clear wins.
- R11: The interrupt output is 1 exactly when at least one status flag is set and that flag's mask input is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| err_lbpv | input | 1 | Line-side bipolar violation pulse |
| err_lexz | input | 1 | Line-side excess-zeros pulse |
| err_sbpv | input | 1 | System-side bipolar violation pulse |
| err_sexz | input | 1 | System-side excess-zeros pulse |
| err_patt | input | 1 | Pattern-checker error pulse |
| src_sel | input | 3 | Error source select |
| tx_nrz | input | 1 | Transmit single-rail NRZ format flag |
| auto_mode | input | 1 | 1 = automatic update on the tick, 0 = manual |
| upd_strobe | input | 1 | Manual update request, one cycle |
| sec_tick | input | 1 | One-second expiry pulse |
| tmr_clr | input | 1 | Clears the timer status flag |
| ovf_clr | input | 1 | Clears the overflow status flag |
| tmr_mask | input | 1 | Masks the timer status from the interrupt |
| ovf_mask | input | 1 | Masks the overflow status from the interrupt |
| hold_val | output | 16 | Holding register value |
| tmr_stat | output | 1 | Timer status flag |
| ovf_stat | output | 1 | Overflow status flag |
| irq | output | 1 | Masked interrupt output |

## Verification
The assertions check several rules on every cycle:
- The holding value stays still between update events.
- After an update event, the holding value equals the count from before the event, and the new count is at most 2.
- The count never falls except at an update event.
- The timer flag rises only after an automatic tick.
- The interrupt stays low when nothing unmasked is pending.

Other behaviour can only be shown by the bench's scenarios. These are the weights of the seven select codes and the NRZ gating, the exact count an interval carries across a transfer, and saturation and overflow after a long run of errors.

// File: rtl/line_err_pkg.sv
package line_err_pkg;
    localparam int CNT_W = 16;
    localparam int INC_W = 2;

    typedef enum logic [2:0] {
        SRC_LBPV  = 3'd0,
        SRC_LEXZ  = 3'd1,
        SRC_LSUM  = 3'd2,
        SRC_SBPV  = 3'd3,
        SRC_SEXZ  = 3'd4,
        SRC_SSUM  = 3'd5,
        SRC_PATT  = 3'd6,
        SRC_NONE  = 3'd7
    } err_src_e;

    typedef struct packed {
        logic tmr;
        logic ovf;
    } stat_t;
endpackage

// File: rtl/err_src_mux.sv
module err_src_mux
    import line_err_pkg::*;
#(
    parameter int IW = INC_W
) (
    input  logic          err_lbpv,
    input  logic          err_lexz,
    input  logic          err_sbpv,
    input  logic          err_sexz,
    input  logic          err_patt,
    input  logic [2:0]    src_sel,
    input  logic          tx_nrz,
    output logic [IW-1:0] inc
);
    logic [IW-1:0] lbpv_w, lexz_w, sbpv_w, sexz_w, patt_w;

    always_comb begin
        lbpv_w = IW'(err_lbpv);
        lexz_w = IW'(err_lexz);
        sbpv_w = IW'(err_sbpv);
        sexz_w = IW'(err_sexz);
        patt_w = IW'(err_patt);
        inc    = '0;
        case (err_src_e'(src_sel))
            SRC_LBPV: inc = lbpv_w;
            SRC_LEXZ: inc = lexz_w;
            SRC_LSUM: inc = lbpv_w + lexz_w;
            SRC_SBPV: inc = tx_nrz ? '0 : sbpv_w;
            SRC_SEXZ: inc = sexz_w;
            SRC_SSUM: inc = tx_nrz ? '0 : (sbpv_w + sexz_w);
            SRC_PATT: inc = patt_w;
            default:  inc = '0;
        endcase
    end
endmodule

// File: rtl/err_accum.sv
module err_accum
    import line_err_pkg::*;
#(
    parameter int W  = CNT_W,
    parameter int IW = INC_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] inc,
    input  logic          auto_mode,
    input  logic          upd_strobe,
    input  logic          sec_tick,
    output logic [W-1:0]  count,
    output logic [W-1:0]  hold_val,
    output logic          ovf_evt
);
    localparam logic [W:0]   LIMIT = {1'b0, {W{1'b1}}};
    localparam logic [W-1:0] ALL1  = {W{1'b1}};

    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] hold;
    } acc_t;

    acc_t acc_d, acc_q;
    logic upd_evt;
    logic [W:0] sum;

    always_comb begin
        acc_d   = acc_q;
        ovf_evt = 1'b0;
        upd_evt = auto_mode ? sec_tick : upd_strobe;
        sum     = {1'b0, acc_q.cnt} + {{(W + 1 - IW){1'b0}}, inc};
        if (upd_evt) begin
            acc_d.hold = acc_q.cnt;
            acc_d.cnt  = {{(W - IW){1'b0}}, inc};
        end else if (sum > LIMIT) begin
            acc_d.cnt = ALL1;
            ovf_evt   = 1'b1;
        end else begin
            acc_d.cnt = sum[W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign count    = acc_q.cnt;
    assign hold_val = acc_q.hold;
endmodule

// File: rtl/err_irq_ctrl.sv
module err_irq_ctrl
    import line_err_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tmr_set,
    input  logic ovf_set,
    input  logic tmr_clr,
    input  logic ovf_clr,
    input  logic tmr_mask,
    input  logic ovf_mask,
    output logic tmr_stat,
    output logic ovf_stat,
    output logic irq
);
    stat_t st_d, st_q;

    always_comb begin
        st_d.tmr = tmr_set | (st_q.tmr & ~tmr_clr);
        st_d.ovf = ovf_set | (st_q.ovf & ~ovf_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tmr_stat = st_q.tmr;
    assign ovf_stat = st_q.ovf;
    assign irq      = (st_q.tmr & ~tmr_mask) | (st_q.ovf & ~ovf_mask);
endmodule

// File: rtl/line_err_counter.sv
module line_err_counter
    import line_err_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             err_lbpv,
    input  logic             err_lexz,
    input  logic             err_sbpv,
    input  logic             err_sexz,
    input  logic             err_patt,
    input  logic [2:0]       src_sel,
    input  logic             tx_nrz,
    input  logic             auto_mode,
    input  logic             upd_strobe,
    input  logic             sec_tick,
    input  logic             tmr_clr,
    input  logic             ovf_clr,
    input  logic             tmr_mask,
    input  logic             ovf_mask,
    output logic [CNT_W-1:0] hold_val,
    output logic             tmr_stat,
    output logic             ovf_stat,
    output logic             irq
);
    logic [INC_W-1:0] inc_w;
    logic [CNT_W-1:0] count_w;
    logic             ovf_evt_w;

    err_src_mux #(.IW(INC_W)) u_mux (
        .err_lbpv (err_lbpv),
        .err_lexz (err_lexz),
        .err_sbpv (err_sbpv),
        .err_sexz (err_sexz),
        .err_patt (err_patt),
        .src_sel  (src_sel),
        .tx_nrz   (tx_nrz),
        .inc      (inc_w)
    );

    err_accum #(.W(CNT_W), .IW(INC_W)) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .inc        (inc_w),
        .auto_mode  (auto_mode),
        .upd_strobe (upd_strobe),
        .sec_tick   (sec_tick),
        .count      (count_w),
        .hold_val   (hold_val),
        .ovf_evt    (ovf_evt_w)
    );

    err_irq_ctrl u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tmr_set  (auto_mode & sec_tick),
        .ovf_set  (ovf_evt_w),
        .tmr_clr  (tmr_clr),
        .ovf_clr  (ovf_clr),
        .tmr_mask (tmr_mask),
        .ovf_mask (ovf_mask),
        .tmr_stat (tmr_stat),
        .ovf_stat (ovf_stat),
        .irq      (irq)
    );
endmodule

// File: rtl/line_err_counter_chk.sv
module line_err_counter_chk
    import line_err_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             auto_mode,
    input logic             sec_tick,
    input logic             upd_strobe,
    input logic             tmr_mask,
    input logic             ovf_mask,
    input logic [CNT_W-1:0] hold_val,
    input logic [CNT_W-1:0] cnt,
    input logic             tmr_stat,
    input logic             ovf_stat,
    input logic             irq
);
    logic upd;
    assign upd = auto_mode ? sec_tick : upd_strobe;

    // R7
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(hold_val));

    // R5
    hold_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> hold_val == $past(cnt));

    // R8
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> cnt <= CNT_W'(2));

    // R10
    no_decrease_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> cnt >= $past(cnt));

    // R9
    tmr_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmr_stat) |-> $past(auto_mode && sec_tick));

    // R11
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((!tmr_stat || tmr_mask) && (!ovf_stat || ovf_mask)) |-> !irq);
endmodule

bind line_err_counter line_err_counter_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .auto_mode  (auto_mode),
    .sec_tick   (sec_tick),
    .upd_strobe (upd_strobe),
    .tmr_mask   (tmr_mask),
    .ovf_mask   (ovf_mask),
    .hold_val   (hold_val),
    .cnt        (count_w),
    .tmr_stat   (tmr_stat),
    .ovf_stat   (ovf_stat),
    .irq        (irq)
);

// File: tb/line_err_counter_test.sv
module line_err_counter_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic err_lbpv = 0, err_lexz = 0, err_sbpv = 0, err_sexz = 0, err_patt = 0;
    logic [2:0] src_sel = 3'd0;
    logic tx_nrz = 0, auto_mode = 0, upd_strobe = 0, sec_tick = 0;
    logic tmr_clr = 0, ovf_clr = 0, tmr_mask = 0, ovf_mask = 0;
    logic [15:0] hold_val;
    logic tmr_stat, ovf_stat, irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    line_err_counter uut (
        .clk(clk), .rst_n(rst_n),
        .err_lbpv(err_lbpv), .err_lexz(err_lexz), .err_sbpv(err_sbpv),
        .err_sexz(err_sexz), .err_patt(err_patt),
        .src_sel(src_sel), .tx_nrz(tx_nrz), .auto_mode(auto_mode),
        .upd_strobe(upd_strobe), .sec_tick(sec_tick),
        .tmr_clr(tmr_clr), .ovf_clr(ovf_clr),
        .tmr_mask(tmr_mask), .ovf_mask(ovf_mask),
        .hold_val(hold_val), .tmr_stat(tmr_stat), .ovf_stat(ovf_stat), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic set_errs(input logic [4:0] v);
        {err_patt, err_sexz, err_sbpv, err_lexz, err_lbpv} = v;
    endtask

    // one manual transfer; errors idle during it
    task automatic manual_read(output logic [15:0] v);
        set_errs(5'b0);
        upd_strobe = 1'b1;
        @(negedge clk);
        upd_strobe = 1'b0;
        v = hold_val;
    endtask

    function automatic int exp_inc(input int sel, input logic [4:0] v, input logic nrz);
        case (sel)
            0: return int'(v[0]);
            1: return int'(v[1]);
            2: return int'(v[0]) + int'(v[1]);
            3: return nrz ? 0 : int'(v[2]);
            4: return int'(v[3]);
            5: return nrz ? 0 : int'(v[2]) + int'(v[3]);
            6: return int'(v[4]);
            default: return 0;
        endcase
    endfunction

    task automatic test_reset();
        check("R1 hold", int'(hold_val), 0);
        check("R1 tmr", int'(tmr_stat), 0);
        check("R1 ovf", int'(ovf_stat), 0);
        check("R1 irq", int'(irq), 0);
    endtask

    // R2 R3 R4: each select, with and without NRZ flag
    task automatic test_sources();
        logic [15:0] v;
        auto_mode = 1'b0;
        for (int nrz = 0; nrz < 2; nrz++) begin
            for (int sel = 0; sel < 8; sel++) begin
                int exp = 0;
                tx_nrz = 1'(nrz);
                src_sel = 3'(sel);
                manual_read(v);
                for (int k = 0; k < 12; k++) begin
                    logic [4:0] pv;
                    pv = 5'(k * 7 + 3);
                    if (k == 11) pv = 5'b11111;
                    set_errs(pv);
                    exp += exp_inc(sel, pv, 1'(nrz));
                    @(negedge clk);
                end
                manual_read(v);
                check($sformatf("R2/R3/R4 sel=%0d nrz=%0d", sel, nrz), int'(v), exp);
            end
        end
        tx_nrz = 1'b0;
    endtask

    // R6 R7 R8 R9 R11: automatic mode
    task automatic test_auto();
        logic [15:0] v;
        src_sel = 3'd0;
        manual_read(v);
        auto_mode = 1'b1;
        set_errs(5'b00001);
        repeat (4) @(negedge clk);
        set_errs(5'b0);
        upd_strobe = 1'b1;
        @(negedge clk);
        upd_strobe = 1'b0;
        check("R6 strobe ignored in auto", int'(hold_val), 0);
        check("R9 no tick no tmr", int'(tmr_stat), 0);
        set_errs(5'b00001);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
        set_errs(5'b0);
        check("R6 tick transfer", int'(hold_val), 4);
        check("R9 tmr set", int'(tmr_stat), 1);
        check("R11 irq tmr", int'(irq), 1);
        tmr_mask = 1'b1;
        #1;
        check("R11 tmr masked", int'(irq), 0);
        tmr_mask = 1'b0;
        set_errs(5'b00001);
        repeat (2) @(negedge clk);
        set_errs(5'b0);
        check("R7 hold kept", int'(hold_val), 4);
        sec_tick = 1'b1;
        tmr_clr = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
        tmr_clr = 1'b0;
        check("R8 carried error", int'(hold_val), 3);
        check("R9 set beats clear", int'(tmr_stat), 1);
        tmr_clr = 1'b1;
        @(negedge clk);
        tmr_clr = 1'b0;
        check("R9 tmr cleared", int'(tmr_stat), 0);
        check("R11 irq idle", int'(irq), 0);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
        check("R7 overwritten", int'(hold_val), 0);
        tmr_clr = 1'b1;
        @(negedge clk);
        tmr_clr = 1'b0;
    endtask

    // R5: tick ignored in manual mode
    task automatic test_manual();
        logic [15:0] v;
        auto_mode = 1'b0;
        src_sel = 3'd6;
        manual_read(v);
        set_errs(5'b10000);
        repeat (3) @(negedge clk);
        set_errs(5'b0);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
        check("R5 tick no transfer", int'(hold_val), 0);
        check("R5 tick no tmr", int'(tmr_stat), 0);
        manual_read(v);
        check("R5 strobe transfer", int'(v), 3);
    endtask

    // R10: saturation and overflow
    task automatic test_overflow();
        logic [15:0] v;
        auto_mode = 1'b0;
        src_sel = 3'd2;
        manual_read(v);
        set_errs(5'b00011);
        repeat (32767) @(negedge clk);
        check("R10 no ovf at 0xFFFE", int'(ovf_stat), 0);
        @(negedge clk);
        set_errs(5'b0);
        check("R10 ovf set", int'(ovf_stat), 1);
        check("R11 irq ovf", int'(irq), 1);
        ovf_mask = 1'b1;
        #1;
        check("R11 ovf masked", int'(irq), 0);
        ovf_mask = 1'b0;
        set_errs(5'b00001);
        @(negedge clk);
        manual_read(v);
        check("R10 saturated", int'(v), 16'hFFFF);
        ovf_clr = 1'b1;
        @(negedge clk);
        ovf_clr = 1'b0;
        check("R10 ovf cleared", int'(ovf_stat), 0);
        manual_read(v);
        check("R10 restart zero", int'(v), 0);
    endtask

    initial begin
        #1;
        check("R1 hold in reset", int'(hold_val), 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_sources();
        test_auto();
        test_manual();
        test_overflow();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule